// File: doc/BRIEF.md
# Programmable Address Translation Window Unit

This block sits on the host side of a bus bridge and maps addresses between the processor's view of memory and the attached bus. Software programs a small number of outbound windows, which carry processor addresses onto the bus, and inbound windows, which carry bus addresses into processor memory. Programming goes through a 32-bit register port that covers a 4 KB offset space.

Each window holds a page-granular base, a page-granular translation target, an attribute word and one extension word. The attribute word carries an enable bit and a six-bit power-of-two size code. Two combinational lookup ports, one for each direction, compare a 44-bit address against the enabled windows of that direction. Each port returns a hit flag, the index of the winning window and the translated address.

The extension words and a control timer word are storage only. No lookup reads them.

Top module: `xlate_window_unit`

## Requirements
- R1: After reset every register reads zero, every window is disabled, and both lookup ports report a miss.
- R2: Outbound window n (n = 1..4) occupies offsets 0xC00 + 32*n. In that set, +0x0 holds the target page, +0x4 holds the extension word, +0x8 holds the base page and +0x10 holds the attributes. Inbound window k (k = 0..2) occupies offsets 0xDA0 + 32*k. In that set, +0x0 holds the target page, +0x8 holds the base page, +0xC holds the extension word and +0x10 holds the attributes. Every one of these registers reads back the full 32-bit value last written to it.
- R3: A read of any other offset returns zero. This includes the configuration ports at 0x0 and 0x4 and the unused words inside a window set. A write to any such offset changes no register and no lookup result.
- R4: Offset 0xE20 is a 32-bit read/write storage word with no other effect.
- R5: A window whose base register holds B and whose attribute bits [5:0] hold C covers the addresses a that satisfy B*4096 <= a < B*4096 + (2 << C). Addresses are 44 bits wide, and a window that runs past the top of the address space covers everything from its base upward.
- R6: On a hit the translated address is T*4096 + (a - B*4096), taken modulo 2^44, where T is the target register.
- R7: Attribute bit 31 enables a window. A window with that bit clear never hits.
- R8: When several enabled windows of one direction cover the address, the lookup reports the lowest index. Outbound windows are numbered 1..4, and inbound windows are numbered 0..2.
- R9: On a miss the port drives its hit flag, its index and its translated address all to zero.
- R10: A register write takes effect for lookups from the clock cycle after the write edge. During the write cycle, lookups still use the previous configuration.
- R11: The extension words have no effect on any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ob_addr_i | input | 44 | Outbound lookup address |
| ob_hit_o | output | 1 | Outbound hit |
| ob_idx_o | output | 3 | Outbound winning window (1..4) |
| ob_xaddr_o | output | 44 | Outbound translated address |
| ib_addr_i | input | 44 | Inbound lookup address |
| ib_hit_o | output | 1 | Inbound hit |
| ib_idx_o | output | 2 | Inbound winning window (0..2) |
| ib_xaddr_o | output | 44 | Inbound translated address |

## Verification
A register write and a lookup that depends on the window being written can occur in the same cycle. To provoke this, the bench holds a lookup address steady on a disabled window and drives the attribute write that enables it. The bench samples the lookup port once between the write being presented and the clock edge, where it expects the old miss, and once after the edge, where it expects the new hit. An assertion checks the opposite case: disabling a window must remove its hit from the following cycle.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int REG_W   = 32;
  localparam int PAGE_SH = 12;
  localparam int AW      = REG_W + PAGE_SH;
  localparam int SZ_W    = 6;
  localparam int SPAN_W  = (1 << SZ_W) + 1;
  localparam int EN_BIT  = 31;
  localparam int OFS_W   = 12;

  localparam logic [OFS_W-1:0] SET_MASK  = 12'hFE0;
  localparam logic [OFS_W-1:0] OB_FIRST  = 12'hC20;
  localparam logic [OFS_W-1:0] IB_FIRST  = 12'hDA0;
  localparam logic [OFS_W-1:0] SET_STEP  = 12'h020;
  localparam logic [OFS_W-1:0] TIMER_OFS = 12'hE20;

  localparam logic [4:0] W_TGT  = 5'h00;
  localparam logic [4:0] W_OEXT = 5'h04;
  localparam logic [4:0] W_BASE = 5'h08;
  localparam logic [4:0] W_IEXT = 5'h0C;
  localparam logic [4:0] W_ATTR = 5'h10;

  function automatic logic [AW-1:0] page_addr(input logic [REG_W-1:0] pg);
    return {pg, {PAGE_SH{1'b0}}};
  endfunction

  function automatic logic win_contains(input logic [AW-1:0] a,
                                        input logic [AW-1:0] base,
                                        input logic [SZ_W-1:0] code);
    logic [SPAN_W-1:0] span;
    logic [SPAN_W-1:0] off;
    span = SPAN_W'(2) << code;
    off  = SPAN_W'(a - base);
    return (a >= base) && (off < span);
  endfunction

  function automatic logic [AW-1:0] win_xlate(input logic [AW-1:0] a,
                                              input logic [AW-1:0] base,
                                              input logic [AW-1:0] tgt);
    return tgt + (a - base);
  endfunction

  function automatic logic [OFS_W-1:0] ob_slot(input int o);
    return OB_FIRST + OFS_W'(o * 32);
  endfunction

  function automatic logic [OFS_W-1:0] ib_slot(input int k);
    return IB_FIRST + OFS_W'(k * 32);
  endfunction
endpackage

// File: rtl/xw_regfile.sv
module xw_regfile
  import xw_pkg::*;
#(
  parameter int NUM_OB = 4,
  parameter int NUM_IB = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [OFS_W-1:0]              addr,
  input  logic [REG_W-1:0]              wdata,
  output logic [REG_W-1:0]              rdata,
  output logic [NUM_OB-1:0][REG_W-1:0]  ob_base,
  output logic [NUM_OB-1:0][REG_W-1:0]  ob_tgt,
  output logic [NUM_OB-1:0]             ob_en,
  output logic [NUM_OB-1:0][SZ_W-1:0]   ob_code,
  output logic [NUM_IB-1:0][REG_W-1:0]  ib_base,
  output logic [NUM_IB-1:0][REG_W-1:0]  ib_tgt,
  output logic [NUM_IB-1:0]             ib_en,
  output logic [NUM_IB-1:0][SZ_W-1:0]   ib_code,
  output logic [REG_W-1:0]              timer_q
);
  logic [NUM_OB-1:0][REG_W-1:0] ob_tgt_q, ob_ext_q, ob_base_q, ob_attr_q;
  logic [NUM_IB-1:0][REG_W-1:0] ib_tgt_q, ib_ext_q, ib_base_q, ib_attr_q;
  logic [REG_W-1:0]             tmr_q;

  logic [OFS_W-1:0] set_sel;
  logic [4:0]       word_sel;
  assign set_sel  = addr & SET_MASK;
  assign word_sel = addr[4:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ob_tgt_q  <= '0;
      ob_ext_q  <= '0;
      ob_base_q <= '0;
      ob_attr_q <= '0;
      ib_tgt_q  <= '0;
      ib_ext_q  <= '0;
      ib_base_q <= '0;
      ib_attr_q <= '0;
      tmr_q     <= '0;
    end else if (wr) begin
      for (int o = 0; o < NUM_OB; o++) begin
        if (set_sel == ob_slot(o)) begin
          case (word_sel)
            W_TGT:   ob_tgt_q[o]  <= wdata;
            W_OEXT:  ob_ext_q[o]  <= wdata;
            W_BASE:  ob_base_q[o] <= wdata;
            W_ATTR:  ob_attr_q[o] <= wdata;
            default: ;
          endcase
        end
      end
      for (int k = 0; k < NUM_IB; k++) begin
        if (set_sel == ib_slot(k)) begin
          case (word_sel)
            W_TGT:   ib_tgt_q[k]  <= wdata;
            W_BASE:  ib_base_q[k] <= wdata;
            W_IEXT:  ib_ext_q[k]  <= wdata;
            W_ATTR:  ib_attr_q[k] <= wdata;
            default: ;
          endcase
        end
      end
      if (addr == TIMER_OFS) tmr_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int o = 0; o < NUM_OB; o++) begin
      if (set_sel == ob_slot(o)) begin
        case (word_sel)
          W_TGT:   rdata = ob_tgt_q[o];
          W_OEXT:  rdata = ob_ext_q[o];
          W_BASE:  rdata = ob_base_q[o];
          W_ATTR:  rdata = ob_attr_q[o];
          default: ;
        endcase
      end
    end
    for (int k = 0; k < NUM_IB; k++) begin
      if (set_sel == ib_slot(k)) begin
        case (word_sel)
          W_TGT:   rdata = ib_tgt_q[k];
          W_BASE:  rdata = ib_base_q[k];
          W_IEXT:  rdata = ib_ext_q[k];
          W_ATTR:  rdata = ib_attr_q[k];
          default: ;
        endcase
      end
    end
    if (addr == TIMER_OFS) rdata = tmr_q;
  end

  for (genvar g = 0; g < NUM_OB; g++) begin : g_ob_fields
    assign ob_base[g] = ob_base_q[g];
    assign ob_tgt[g]  = ob_tgt_q[g];
    assign ob_en[g]   = ob_attr_q[g][EN_BIT];
    assign ob_code[g] = ob_attr_q[g][SZ_W-1:0];
  end
  for (genvar g = 0; g < NUM_IB; g++) begin : g_ib_fields
    assign ib_base[g] = ib_base_q[g];
    assign ib_tgt[g]  = ib_tgt_q[g];
    assign ib_en[g]   = ib_attr_q[g][EN_BIT];
    assign ib_code[g] = ib_attr_q[g][SZ_W-1:0];
  end
  assign timer_q = tmr_q;
endmodule

// File: rtl/xw_lookup.sv
module xw_lookup
  import xw_pkg::*;
#(
  parameter int N       = 4,
  parameter int IW      = 3,
  parameter int IDX_OFS = 0
) (
  input  logic [AW-1:0]             addr,
  input  logic [N-1:0][REG_W-1:0]   base_pg,
  input  logic [N-1:0][REG_W-1:0]   tgt_pg,
  input  logic [N-1:0]              en,
  input  logic [N-1:0][SZ_W-1:0]    code,
  output logic                      hit,
  output logic [IW-1:0]             idx,
  output logic [AW-1:0]             xaddr,
  output logic [N-1:0]              hit_vec
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = en[g] && win_contains(addr, page_addr(base_pg[g]), code[g]);
  end

  always_comb begin
    hit   = 1'b0;
    idx   = '0;
    xaddr = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit   = 1'b1;
        idx   = IW'(i + IDX_OFS);
        xaddr = win_xlate(addr, page_addr(base_pg[i]), page_addr(tgt_pg[i]));
      end
    end
  end
endmodule

// File: rtl/xlate_window_unit.sv
module xlate_window_unit
  import xw_pkg::*;
#(
  parameter int NUM_OB = 4,
  parameter int NUM_IB = 3,
  localparam int OB_IW = $clog2(NUM_OB + 1),
  localparam int IB_IW = (NUM_IB > 1) ? $clog2(NUM_IB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [11:0]      reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [43:0]      ob_addr_i,
  output logic             ob_hit_o,
  output logic [OB_IW-1:0] ob_idx_o,
  output logic [43:0]      ob_xaddr_o,
  input  logic [43:0]      ib_addr_i,
  output logic             ib_hit_o,
  output logic [IB_IW-1:0] ib_idx_o,
  output logic [43:0]      ib_xaddr_o
);
  logic [NUM_OB-1:0][REG_W-1:0] ob_base_w, ob_tgt_w;
  logic [NUM_OB-1:0]            ob_en_w, ob_hv_w;
  logic [NUM_OB-1:0][SZ_W-1:0]  ob_code_w;
  logic [NUM_IB-1:0][REG_W-1:0] ib_base_w, ib_tgt_w;
  logic [NUM_IB-1:0]            ib_en_w, ib_hv_w;
  logic [NUM_IB-1:0][SZ_W-1:0]  ib_code_w;
  logic [REG_W-1:0]             timer_w;

  xw_regfile #(.NUM_OB(NUM_OB), .NUM_IB(NUM_IB)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .ob_base(ob_base_w), .ob_tgt(ob_tgt_w), .ob_en(ob_en_w), .ob_code(ob_code_w),
    .ib_base(ib_base_w), .ib_tgt(ib_tgt_w), .ib_en(ib_en_w), .ib_code(ib_code_w),
    .timer_q(timer_w)
  );

  xw_lookup #(.N(NUM_OB), .IW(OB_IW), .IDX_OFS(1)) ob_look_i (
    .addr(ob_addr_i), .base_pg(ob_base_w), .tgt_pg(ob_tgt_w),
    .en(ob_en_w), .code(ob_code_w),
    .hit(ob_hit_o), .idx(ob_idx_o), .xaddr(ob_xaddr_o), .hit_vec(ob_hv_w)
  );

  xw_lookup #(.N(NUM_IB), .IW(IB_IW), .IDX_OFS(0)) ib_look_i (
    .addr(ib_addr_i), .base_pg(ib_base_w), .tgt_pg(ib_tgt_w),
    .en(ib_en_w), .code(ib_code_w),
    .hit(ib_hit_o), .idx(ib_idx_o), .xaddr(ib_xaddr_o), .hit_vec(ib_hv_w)
  );
endmodule

// File: rtl/xw_checker.sv
module xw_checker #(
  parameter int NUM_OB = 4,
  parameter int NUM_IB = 3,
  parameter int OB_IW  = 3,
  parameter int IB_IW  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [11:0]       reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              ob_hit,
  input logic [OB_IW-1:0]  ob_idx,
  input logic [43:0]       ob_xaddr,
  input logic [NUM_OB-1:0] ob_en,
  input logic [NUM_OB-1:0] ob_hv,
  input logic              ib_hit,
  input logic [IB_IW-1:0]  ib_idx,
  input logic [43:0]       ib_xaddr,
  input logic [NUM_IB-1:0] ib_en,
  input logic [NUM_IB-1:0] ib_hv,
  input logic [31:0]       timer_q
);
  logic [NUM_OB-1:0] ob_below;
  logic [NUM_IB-1:0] ib_below;
  assign ob_below = NUM_OB'((1 << (ob_idx - 1'b1)) - 1);
  assign ib_below = NUM_IB'((1 << ib_idx) - 1);

  a_r9_ob_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ob_hit |-> (ob_idx == '0 && ob_xaddr == '0));
  a_r9_ib_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ib_hit |-> (ib_idx == '0 && ib_xaddr == '0));
  a_r7_ob_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    ob_hit |-> (ob_idx != '0 && ob_en[ob_idx - 1'b1]));
  a_r7_ib_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    ib_hit |-> ib_en[ib_idx]);
  a_r8_ob_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ob_hit |-> ((ob_hv & ob_below) == '0));
  a_r8_ib_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ib_hit |-> ((ib_hv & ib_below) == '0));
  a_r10_disable_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 12'hC30 && !reg_wdata[31]) |=> (!ob_en[0] && !(ob_hit && ob_idx == 1)));
  a_r4_timer_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 12'hE20) |=> (timer_q == $past(reg_wdata)));
  a_r4_timer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 12'hE20) |=> $stable(timer_q));
endmodule

bind xlate_window_unit xw_checker #(
  .NUM_OB(NUM_OB), .NUM_IB(NUM_IB), .OB_IW(OB_IW), .IB_IW(IB_IW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata),
  .ob_hit(ob_hit_o), .ob_idx(ob_idx_o), .ob_xaddr(ob_xaddr_o),
  .ob_en(ob_en_w), .ob_hv(ob_hv_w),
  .ib_hit(ib_hit_o), .ib_idx(ib_idx_o), .ib_xaddr(ib_xaddr_o),
  .ib_en(ib_en_w), .ib_hv(ib_hv_w),
  .timer_q(timer_w)
);

// File: tb/xlate_window_unit_tb_top.sv
module xlate_window_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [43:0] ob_addr_i = '0;
  logic        ob_hit_o;
  logic [2:0]  ob_idx_o;
  logic [43:0] ob_xaddr_o;
  logic [43:0] ib_addr_i = '0;
  logic        ib_hit_o;
  logic [1:0]  ib_idx_o;
  logic [43:0] ib_xaddr_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [31:0] m_ob_b [4], m_ob_t [4], m_ob_a [4];
  logic [31:0] m_ib_b [3], m_ib_t [3], m_ib_a [3];

  always #10 clk = ~clk;

  xlate_window_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ob_addr_i(ob_addr_i), .ob_hit_o(ob_hit_o), .ob_idx_o(ob_idx_o), .ob_xaddr_o(ob_xaddr_o),
    .ib_addr_i(ib_addr_i), .ib_hit_o(ib_hit_o), .ib_idx_o(ib_idx_o), .ib_xaddr_o(ib_xaddr_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic bit implemented(input int off);
    int s, w;
    s = off & 'hFE0;
    w = off & 'h1F;
    if (off == 'hE20) return 1'b1;
    if (s >= 'hC20 && s <= 'hC80) return (w == 0 || w == 4 || w == 8 || w == 'h10);
    if (s >= 'hDA0 && s <= 'hDE0) return (w == 0 || w == 8 || w == 'hC || w == 'h10);
    return 1'b0;
  endfunction

  // Coverage computed by shifting the offset rather than comparing against a span.
  function automatic bit covers(input logic [43:0] a, input logic [31:0] b, input logic [31:0] attr);
    logic [43:0] base;
    int c;
    base = {b, 12'h000};
    c = int'(attr[5:0]);
    if (!attr[31] || a < base) return 1'b0;
    if (c >= 43) return 1'b1;
    return ((a - base) >> (c + 1)) == 0;
  endfunction

  task automatic ob_cfg(input int n, input logic [31:0] t, input logic [31:0] e,
                        input logic [31:0] b, input logic [31:0] at);
    logic [11:0] s;
    s = 12'(12'hC00 + n * 32);
    wr(s + 12'h0, t); wr(s + 12'h4, e); wr(s + 12'h8, b); wr(s + 12'h10, at);
    m_ob_t[n-1] = t; m_ob_b[n-1] = b; m_ob_a[n-1] = at;
  endtask

  task automatic ib_cfg(input int k, input logic [31:0] t, input logic [31:0] b,
                        input logic [31:0] e, input logic [31:0] at);
    logic [11:0] s;
    s = 12'(12'hDA0 + k * 32);
    wr(s + 12'h0, t); wr(s + 12'h8, b); wr(s + 12'hC, e); wr(s + 12'h10, at);
    m_ib_t[k] = t; m_ib_b[k] = b; m_ib_a[k] = at;
  endtask

  task automatic look_ob(input logic [43:0] a, input string req);
    bit h; logic [2:0] i; logic [43:0] x;
    h = 1'b0; i = '0; x = '0;
    for (int n = 0; n < 4; n++)
      if (!h && covers(a, m_ob_b[n], m_ob_a[n])) begin
        h = 1'b1; i = 3'(n + 1);
        x = {m_ob_t[n], 12'h000} + (a - {m_ob_b[n], 12'h000});
      end
    ob_addr_i = a;
    #1;
    check(ob_hit_o == h && ob_idx_o == i && ob_xaddr_o == x, req,
          {ob_hit_o, ob_idx_o, 16'h0, ob_xaddr_o}, {h, i, 16'h0, x});
  endtask

  task automatic look_ib(input logic [43:0] a, input string req);
    bit h; logic [1:0] i; logic [43:0] x;
    h = 1'b0; i = '0; x = '0;
    for (int k = 0; k < 3; k++)
      if (!h && covers(a, m_ib_b[k], m_ib_a[k])) begin
        h = 1'b1; i = 2'(k);
        x = {m_ib_t[k], 12'h000} + (a - {m_ib_b[k], 12'h000});
      end
    ib_addr_i = a;
    #1;
    check(ib_hit_o == h && ib_idx_o == i && ib_xaddr_o == x, req,
          {ib_hit_o, ib_idx_o, 17'h0, ib_xaddr_o}, {h, 1'b0, i, 16'h0, x});
  endtask

  task automatic sweep_ob(input string req);
    for (int n = 0; n < 4; n++) begin
      logic [43:0] b, sz;
      b  = {m_ob_b[n], 12'h000};
      sz = (m_ob_a[n][5:0] < 6'd43) ? 44'(64'd2 << m_ob_a[n][5:0]) : 44'h0;
      look_ob(b - 44'd1, req);
      look_ob(b, req);
      look_ob(b + (sz >> 1) + 44'd5, req);
      look_ob(b + sz - 44'd1, req);
      look_ob(b + sz, req);
    end
  endtask

  task automatic sweep_ib(input string req);
    for (int k = 0; k < 3; k++) begin
      logic [43:0] b, sz;
      b  = {m_ib_b[k], 12'h000};
      sz = (m_ib_a[k][5:0] < 6'd43) ? 44'(64'd2 << m_ib_a[k][5:0]) : 44'h0;
      look_ib(b - 44'd1, req);
      look_ib(b, req);
      look_ib(b + (sz >> 1) + 44'd3, req);
      look_ib(b + sz - 44'd1, req);
      look_ib(b + sz, req);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 4; n++) begin m_ob_b[n] = '0; m_ob_t[n] = '0; m_ob_a[n] = '0; end
    for (int k = 0; k < 3; k++) begin m_ib_b[k] = '0; m_ib_t[k] = '0; m_ib_a[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state over the whole offset space and both ports
    for (int off = 0; off < 4096; off += 4) begin
      @(negedge clk); reg_addr = 12'(off); #1;
      check(reg_rdata == 32'h0, "R1 reset read", 64'(reg_rdata), 64'h0);
    end
    look_ob(44'h0, "R1 R9 ob miss at reset");
    look_ib(44'h0, "R1 R9 ib miss at reset");

    // R2 R3 R4: all-ones written to every offset, read back by map
    for (int off = 0; off < 4096; off += 4) wr(12'(off), 32'hFFFF_FFFF);
    for (int off = 0; off < 4096; off += 4) begin
      logic [31:0] e;
      e = implemented(off) ? 32'hFFFF_FFFF : 32'h0;
      @(negedge clk); reg_addr = 12'(off); #1;
      check(reg_rdata == e, implemented(off) ? "R2 R4 readback" : "R3 unmapped reads zero",
            64'(reg_rdata), 64'(e));
    end
    for (int off = 0; off < 4096; off += 4) wr(12'(off), 32'h0);
    look_ob(44'hFFF_FFFF_FFFF, "R1 cleared windows miss");

    // R2: distinct pattern readback
    wr(12'hC44, 32'hA5A5_1234);
    @(negedge clk); reg_addr = 12'hC44; #1;
    check(reg_rdata == 32'hA5A5_1234, "R2 outbound ext readback", 64'(reg_rdata), 64'hA5A51234);
    wr(12'hDCC, 32'h0BAD_F00D);
    @(negedge clk); reg_addr = 12'hDCC; #1;
    check(reg_rdata == 32'h0BAD_F00D, "R2 inbound ext readback", 64'(reg_rdata), 64'h0BADF00D);

    // R4: timer word
    wr(12'hE20, 32'h1357_9BDF);
    @(negedge clk); reg_addr = 12'hE20; #1;
    check(reg_rdata == 32'h1357_9BDF, "R4 timer storage", 64'(reg_rdata), 64'h13579BDF);

    // Outbound configuration: overlap, disabled window, wrap at the top
    ob_cfg(1, 32'h0000_0080, 32'h0, 32'h0000_0010, 32'h8000_000C);
    ob_cfg(2, 32'h0000_0300, 32'h0, 32'h0000_0011, 32'h8000_000D);
    ob_cfg(3, 32'h0000_5000, 32'h0, 32'h0000_0100, 32'h0000_0014);
    ob_cfg(4, 32'h0000_0001, 32'h0, 32'hFFF0_0000, 32'h8000_0028);
    sweep_ob("R5 R6 R8 R7 ob sweep");
    look_ob(44'h0_0001_1800, "R8 overlap lowest index");
    look_ob(44'h0_0010_0400, "R7 disabled window no hit");
    look_ob(44'hFFF_FFFF_FFFF, "R5 window past top covers to end");

    // Inbound: index mapping 0xDA0->0, overlap, huge size
    ib_cfg(0, 32'h0000_0400, 32'h0000_0200, 32'h0, 32'h8000_000B);
    ib_cfg(1, 32'h0000_0900, 32'h0000_0200, 32'h0, 32'h8000_000E);
    ib_cfg(2, 32'h00AB_C000, 32'h0000_0A00, 32'h0, 32'h8000_003F);
    sweep_ib("R5 R6 R8 ib sweep");
    look_ib(44'h0_0020_0800, "R8 ib lowest index at 0xDA0 set");
    look_ib(44'hABC_DEF0_1234, "R5 R6 ib code 63 window");

    // R11: extension words carry no meaning for lookups
    wr(12'hC24, 32'hFFFF_FFFF); wr(12'hC44, 32'h1234_5678);
    wr(12'hC64, 32'hFFFF_FFFF); wr(12'hC84, 32'h8000_003F);
    wr(12'hDAC, 32'hFFFF_FFFF); wr(12'hDCC, 32'h8000_0000); wr(12'hDEC, 32'h0000_003F);
    sweep_ob("R11 ob ext ignored");
    sweep_ib("R11 ib ext ignored");

    // R3: writes to unmapped offsets leave lookups unchanged
    wr(12'hC2C, 32'hFFFF_FFFF); wr(12'hC00, 32'hFFFF_FFFF); wr(12'hDA4, 32'hFFFF_FFFF);
    wr(12'h004, 32'hFFFF_FFFF); wr(12'hC34, 32'h0);
    sweep_ob("R3 unmapped write no effect");

    // R10: enable write vs lookup in the same cycle
    ob_addr_i = 44'h0_0010_0400;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'hC70; reg_wdata = 32'h8000_0014;
    #1;
    check(!ob_hit_o, "R10 old config during write cycle", 64'(ob_hit_o), 64'h0);
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
    check(ob_hit_o && ob_idx_o == 3'd3 && ob_xaddr_o == 44'h0_0500_0400,
          "R10 new config next cycle", {ob_hit_o, ob_idx_o, 16'h0, ob_xaddr_o},
          {1'b1, 3'd3, 16'h0, 44'h0_0500_0400});
    m_ob_a[2] = 32'h8000_0014;
    sweep_ob("R10 R6 after enable");

    // R10: disable takes effect next cycle
    wr(12'hC30, 32'h0000_000C);
    m_ob_a[0] = 32'h0000_000C;
    look_ob(44'h0_0001_0000, "R10 R7 disabled after write");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule